// File: doc/BRIEF.md
# Coefficient Memory Checksum Supervisor

This block guards a 24-bit coefficient RAM that holds two banks: filter coefficients at word addresses 0..39 and dynamics/crossover coefficients at word addresses 40..49. For each bank it computes a bitwise XOR of every word in the bank's range and publishes the result. The host can read the published value as 24-bit ports or through a byte-wide readout. A host-written reference can be compared against each published checksum to produce a per-bank fail bit. A mismatch can also raise a one-cycle device reset request. The coefficient RAM is modelled inside the block as a simple write port plus internal reads.

Each bank has three enables, and each one only counts when the one before it is set. The run enable starts scanning. The compare enable judges each finished scan against the reference. The auto-reset enable turns a judged mismatch into a reset request. A scan starts when the run enable goes high, and again on every accepted frame strobe. Which strobes are accepted depends on a 2-bit rate mode.

Top module: `coef_xor_monitor`

## Requirements
- R1: The bank A checksum (`a_sum`) equals the XOR of RAM words 0 through 39 inclusive.
- R2: The bank B checksum (`b_sum`) equals the XOR of RAM words 40 through 49 inclusive.
- R3: `rd_byte` returns bytes of the published checksums, most significant byte first. `rd_sel` 0, 1 and 2 give `a_sum` bits 23:16, 15:8 and 7:0. `rd_sel` 3, 4 and 5 give the same bytes of `b_sum`. `rd_sel` 6 and 7 give 0.
- R4: A scan starts at the first clock edge that sees a bank's `go_en` bit newly high. The bank reads one word per clock from its lowest address. Its checksum output changes at the 41st edge (bank A) or the 11th edge (bank B) counted from that edge.
- R5: When `rate_mode` is 01 or 10, every `frame_tick` pulse starts a new scan of each running bank. For the values 00 and 11, only every second pulse starts a scan: the pulse counted as zero, two, four and so on since reset, where every pulse counts whatever the mode.
- R6: When a scan finishes while the bank's `go_en` and `cmp_en` bits are set, the bank's `fail` bit becomes 0 if the checksum equals its reference (`a_ref` or `b_ref`) and 1 otherwise. When `cmp_en` is clear, `fail` keeps its value.
- R7: `cmp_en` has no effect while the same bank's `go_en` bit is clear.
- R8: Both `fail` bits are 1 after reset and stay 1 until a compared scan matches.
- R9: `reset_req` is high for exactly one cycle when a bank finishes a mismatching scan with `go_en`, `cmp_en` and `auto_en` all set. `auto_en` has no effect while `cmp_en` is clear.
- R10: Clearing a bank's `go_en` stops its scans, and its published checksum keeps its last value.
- R11: After reset both checksums read 0 and `reset_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ram_we | input | 1 | Coefficient RAM write strobe |
| ram_waddr | input | 6 | Coefficient RAM word address |
| ram_wdata | input | 24 | Coefficient RAM write data |
| frame_tick | input | 1 | One-cycle pulse per processing sample period |
| rate_mode | input | 2 | Sample-rate mode; 01 and 10 select full update rate |
| go_en | input | 2 | Run enable per bank (bit 0 bank A, bit 1 bank B) |
| cmp_en | input | 2 | Compare enable per bank |
| auto_en | input | 2 | Auto-reset enable per bank |
| a_ref | input | 24 | Bank A reference checksum |
| b_ref | input | 24 | Bank B reference checksum |
| rd_sel | input | 3 | Byte readout select |
| rd_byte | output | 8 | Selected checksum byte |
| a_sum | output | 24 | Published bank A checksum |
| b_sum | output | 24 | Published bank B checksum |
| fail | output | 2 | Per-bank compare result, 1 means mismatch or not yet matched |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The bench builds the block with its default bank ranges: 40 words for bank A and 10 words for bank B. A full scan therefore fits well inside the waits the bench uses, and the exact 41- and 11-edge publish points can be checked directly. The bench keeps its own count of frame pulses, so it can predict which pulses start a scan in every `rate_mode` value. It then checks the enable chain by setting and clearing each bank's run, compare and auto-reset bits in separate scenarios.

// File: rtl/coef_xor_monitor.sv
module coef_xor_monitor #(
  parameter int AW   = 6,
  parameter int A_LO = 0,
  parameter int A_HI = 39,
  parameter int B_LO = 40,
  parameter int B_HI = 49
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ram_we,
  input  logic [AW-1:0] ram_waddr,
  input  logic [23:0] ram_wdata,
  input  logic        frame_tick,
  input  logic [1:0]  rate_mode,
  input  logic [1:0]  go_en,
  input  logic [1:0]  cmp_en,
  input  logic [1:0]  auto_en,
  input  logic [23:0] a_ref,
  input  logic [23:0] b_ref,
  input  logic [2:0]  rd_sel,
  output logic [7:0]  rd_byte,
  output logic [23:0] a_sum,
  output logic [23:0] b_sum,
  output logic [1:0]  fail,
  output logic        reset_req
);
  localparam int DW    = 24;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  always_ff @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;

  logic phase;
  wire  full_rate = (rate_mode == 2'b01) || (rate_mode == 2'b10);
  wire  upd       = frame_tick && (full_rate || !phase);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          phase <= 1'b0;
    else if (frame_tick) phase <= ~phase;

  logic [DW-1:0] ref_w [2];
  logic [DW-1:0] sum_w [2];
  logic [1:0]    req_w;

  assign ref_w[0] = a_ref;
  assign ref_w[1] = b_ref;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam int LO = (g == 0) ? A_LO : B_LO;
    localparam int HI = (g == 0) ? A_HI : B_HI;

    logic          busy, go_d, fail_r, req_r;
    logic [AW-1:0] ptr;
    logic [DW-1:0] acc, sum_r;
    wire  [DW-1:0] nxt   = acc ^ mem[ptr];
    wire           start = go_en[g] && (upd || !go_d);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        busy   <= 1'b0;
        go_d   <= 1'b0;
        ptr    <= '0;
        acc    <= '0;
        sum_r  <= '0;
        fail_r <= 1'b1;
        req_r  <= 1'b0;
      end else begin
        go_d  <= go_en[g];
        req_r <= 1'b0;
        if (!go_en[g]) begin
          busy <= 1'b0;
        end else if (start) begin
          busy <= 1'b1;
          ptr  <= AW'(LO);
          acc  <= '0;
        end else if (busy) begin
          acc <= nxt;
          ptr <= ptr + 1'b1;
          if (ptr == AW'(HI)) begin
            busy  <= 1'b0;
            sum_r <= nxt;
            if (cmp_en[g]) begin
              fail_r <= (nxt != ref_w[g]);
              req_r  <= auto_en[g] && (nxt != ref_w[g]);
            end
          end
        end
      end

    assign sum_w[g] = sum_r;
    assign fail[g]  = fail_r;
    assign req_w[g] = req_r;
  end

  assign a_sum     = sum_w[0];
  assign b_sum     = sum_w[1];
  assign reset_req = |req_w;

  always_comb
    case (rd_sel)
      3'd0:    rd_byte = a_sum[23:16];
      3'd1:    rd_byte = a_sum[15:8];
      3'd2:    rd_byte = a_sum[7:0];
      3'd3:    rd_byte = b_sum[23:16];
      3'd4:    rd_byte = b_sum[15:8];
      3'd5:    rd_byte = b_sum[7:0];
      default: rd_byte = 8'h00;
    endcase
endmodule

module coef_xor_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  go_en,
  input logic [1:0]  cmp_en,
  input logic [1:0]  auto_en,
  input logic [23:0] a_sum,
  input logic [23:0] b_sum,
  input logic [1:0]  fail,
  input logic        reset_req
);
  assert_req_needs_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(|(go_en & cmp_en & auto_en)));
  assert_req_shows_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (fail != 2'b00));
  assert_a_sum_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !go_en[0] |=> $stable(a_sum));
  assert_b_sum_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !go_en[1] |=> $stable(b_sum));
  assert_a_fail_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_en[0] && cmp_en[0]) |=> $stable(fail[0]));
  assert_b_fail_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_en[1] && cmp_en[1]) |=> $stable(fail[1]));
endmodule

bind coef_xor_monitor coef_xor_monitor_chk u_chk (.*);

// File: tb/tb_coef_xor_monitor.sv
module tb_coef_xor_monitor;
  logic clk = 0, rst_n = 0;
  logic ram_we = 0;
  logic [5:0] ram_waddr = 0;
  logic [23:0] ram_wdata = 0;
  logic frame_tick = 0;
  logic [1:0] rate_mode = 2'b01, go_en = 0, cmp_en = 0, auto_en = 0;
  logic [23:0] a_ref = 0, b_ref = 0;
  logic [2:0] rd_sel = 0;
  logic [7:0] rd_byte;
  logic [23:0] a_sum, b_sum;
  logic [1:0] fail;
  logic reset_req;

  int total = 0, bad = 0, ticks = 0, req_cnt = 0;
  bit finished = 0;
  logic [23:0] model [64];

  always #2 clk = ~clk;

  coef_xor_monitor dut (.*);

  always @(negedge clk) if (reset_req) req_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] xsum(int lo, int hi);
    logic [23:0] s = 0;
    for (int i = lo; i <= hi; i++) s ^= model[i];
    return s;
  endfunction

  task automatic wr(int a, logic [23:0] d);
    @(negedge clk); ram_we = 1; ram_waddr = 6'(a); ram_wdata = d;
    @(negedge clk); ram_we = 0;
    model[a] = d;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    ticks++;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 a_sum", a_sum, 0);
    check("R11 b_sum", b_sum, 0);
    check("R11 reset_req", reset_req, 0);
    check("R8 fail", fail, 2'b11);
  endtask

  task automatic t_start();
    for (int i = 0; i < 64; i++) wr(i, 24'((i * 32'h1357 + 32'hA5) ^ (i << 17)));
    @(negedge clk); go_en[0] = 1;
    repeat (40) @(posedge clk);
    @(negedge clk); check("R4 bank A before edge 41", a_sum, 0);
    @(posedge clk); @(negedge clk);
    check("R4/R1 bank A at edge 41", a_sum, xsum(0, 39));
    go_en[1] = 1;
    repeat (10) @(posedge clk);
    @(negedge clk); check("R4 bank B before edge 11", b_sum, 0);
    @(posedge clk); @(negedge clk);
    check("R4/R2 bank B at edge 11", b_sum, xsum(40, 49));
    check("R8 fail held without compare", fail, 2'b11);
  endtask

  task automatic t_bytes();
    logic [23:0] a = xsum(0, 39), b = xsum(40, 49);
    logic [7:0] exp [8];
    exp = '{a[23:16], a[15:8], a[7:0], b[23:16], b[15:8], b[7:0], 8'h00, 8'h00};
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s); #1;
      check($sformatf("R3 rd_sel=%0d", s), rd_byte, exp[s]);
    end
  endtask

  task automatic t_rate();
    logic [23:0] expb = xsum(40, 49);
    for (int m = 0; m < 4; m++) begin
      rate_mode = 2'(m);
      for (int k = 0; k < 2; k++) begin
        bit full = (m == 1) || (m == 2);
        bit take = full || (ticks % 2 == 0);
        wr(45, 24'(32'h5A0000 + m * 16 + k + 1));
        tick();
        idle(15);
        if (take) expb = xsum(40, 49);
        check($sformatf("R5 mode=%0d pulse=%0d", m, k), b_sum, expb);
      end
    end
    rate_mode = 2'b01;
    tick(); idle(15);
  endtask

  task automatic t_compare();
    b_ref = xsum(40, 49); cmp_en[1] = 1;
    tick(); idle(15);
    check("R6 bank B match", fail[1], 0);
    b_ref = ~xsum(40, 49);
    tick(); idle(15);
    check("R6 bank B mismatch", fail[1], 1);
    check("R9 no request without auto", req_cnt, 0);
    b_ref = xsum(40, 49);
    tick(); idle(15);
    check("R6 bank B match again", fail[1], 0);
  endtask

  task automatic t_stop();
    logic [23:0] olda;
    tick(); idle(50);
    olda = xsum(0, 39);
    check("R1 bank A refreshed", a_sum, olda);
    @(negedge clk); go_en[0] = 0;
    wr(5, 24'hC0FFEE);
    cmp_en[0] = 1; a_ref = xsum(0, 39);
    tick(); idle(50);
    check("R10 bank A sum held", a_sum, olda);
    check("R7 compare ignored without go", fail[0], 1);
  endtask

  task automatic t_auto();
    req_cnt = 0;
    cmp_en[0] = 1; auto_en[0] = 1; a_ref = ~xsum(0, 39);
    @(negedge clk); go_en[0] = 1;
    idle(50);
    check("R9 one pulse on mismatch", req_cnt, 1);
    check("R9 fail set", fail[0], 1);
    a_ref = xsum(0, 39);
    tick(); idle(50);
    check("R6 bank A match", fail[0], 0);
    check("R9 no pulse on match", req_cnt, 1);
    a_ref = ~xsum(0, 39); cmp_en[0] = 0;
    tick(); idle(50);
    check("R9 auto ignored without compare", req_cnt, 1);
    check("R6 fail held without compare", fail[0], 0);
    cmp_en[0] = 1;
    tick(); idle(50);
    check("R9 second mismatch pulse", req_cnt, 2);
    check("R9 fail after mismatch", fail[0], 1);
    check("R2 bank B unchanged", b_sum, xsum(40, 49));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1;
    idle(2);
    t_reset();
    t_start();
    t_bytes();
    t_rate();
    t_compare();
    t_stop();
    t_auto();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule